// File: doc/BRIEF.md
# Command Bus Slot Allocator

This block keeps a memory command bus from being asked to carry more commands than it can. Time is split into fixed windows, each as long as the data transfer of one burst. Each window can take only a fixed number of commands. A scheduler hands the block a request with the cycle at which it would like the command to go out. The block answers with the cycle at which the command may actually issue.

A command is either single-phase or two-phase. A two-phase command needs a slot for each phase, and its two phases must stay within a maximum separation. The timing target applies to the second phase. The first phase may be placed in an earlier window, but never before cycle zero.

The block records occupancy in a small table of window start cycles with their counts. Windows that begin before the current cycle are removed. Requests arrive over a valid/ready handshake. The answer comes back one cycle after a request is accepted.

Top module: `cmd_slot_alloc`

## Requirements
- R1: The window of a cycle c starts at c rounded down to a multiple of WIN_LEN (default 4). When that window has a free slot, a single-phase grant_second equals the requested cycle.
- R2: No window holds more than MAX_CMD = BURST_LEN / BEATS_PER_CLK commands (default 16/8 = 2).
- R3: A single-phase request whose window is full moves to the start of the next window. This repeats until a window with a free slot is found, and grant_second is that window's start.
- R4: For a two-phase request with offset o = cycle mod WIN_LEN and gap g, the first phase is searched from window start (cycle − o) − B. B is the smallest multiple of WIN_LEN with B + o ≥ g, and the result is clamped at 0.
- R5: When both phases of a two-phase request land in one window, that window must have two free slots.
- R6: A second phase with no free slot moves one window later, and grant_second becomes that window's start. The first phase moves one window later when its own window is full, or when the second phase moved and the two window starts now lie more than g cycles apart in different windows. The search stops when both phases have a slot.
- R7: A window whose start is below cur_cycle is dropped and counts as empty. A new window is recorded only when its start is at or above cur_cycle.
- R8: req_ready is high only when the table has at least one free entry for a single-phase request, or at least two for a two-phase request. A request presented while req_ready is low is not accepted and produces no grant.
- R9: grant_valid is high for exactly the cycle after each acceptance. For a single-phase request, grant_first equals grant_second. For a two-phase request, grant_first is a window start no later than grant_second.
- R10: After reset the table is empty: grant_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_cycle | input | CYC_W | Current cycle, used to drop old windows |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cycle | input | CYC_W | Desired issue cycle of the (second) phase |
| req_two_phase | input | 1 | 1 = two-phase command, 0 = single-phase |
| req_gap | input | GAP_W | Maximum separation between the two phases |
| grant_valid | output | 1 | Grant result present |
| grant_second | output | CYC_W | Granted cycle of the second or only phase |
| grant_first | output | CYC_W | Granted window start of the first phase |

## Verification
Some properties are checked on every cycle:
- the grant timing relative to acceptance,
- that a moved grant lands on a window boundary after the requested cycle,
- the ordering of the two phases,
- the per-window count limit in the table,
- that every recorded window starts at or after the current cycle,
- that ready is only offered when enough entries are free.

Other behaviour can only be shown by the bench's scenarios. This includes the exact cycle a command ends up at after walking past full windows, and how far back the first phase starts and when clamping applies. It also includes the two-slot rule for a shared window and the point at which pruning frees an entry. The bench computes these values arithmetically over a sweep of every gap and offset.

// File: rtl/slot_pkg.sv
// Package: default configuration shared by the slot allocator modules.
// Assumes the default configuration gives a window count limit >= 1.
package slot_pkg;
    parameter int unsigned DEF_CYC_W         = 16;
    parameter int unsigned DEF_WIN_LEN       = 4;
    parameter int unsigned DEF_BURST_LEN     = 16;
    parameter int unsigned DEF_BEATS_PER_CLK = 8;
    parameter int unsigned DEF_N_ENT         = 8;
    parameter int unsigned DEF_GAP_W         = 4;
endpackage

// File: rtl/slot_align.sv
// slot_align: finds the starting windows for a request.
// The second phase starts in the window that holds the requested cycle.
// The first phase starts in the earliest window that lies no further back
// than the phase gap, clamped at cycle zero.
// Assumes WIN_LEN >= 1. Purely combinational.
module slot_align #(
    parameter int unsigned CYC_W   = 16,
    parameter int unsigned GAP_W   = 4,
    parameter int unsigned WIN_LEN = 4
) (
    input  logic [CYC_W-1:0] req_cycle_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic [CYC_W-1:0] sec_win_o,
    output logic [CYC_W-1:0] first_win_o
);
    localparam logic [CYC_W-1:0] STEP = CYC_W'(WIN_LEN);

    logic [CYC_W-1:0] offset;
    logic [CYC_W-1:0] gap_ext;
    logic [CYC_W-1:0] back;

    // Split the cycle into window start and offset, then size the look-back.
    always_comb begin
        offset    = req_cycle_i % STEP;
        sec_win_o = req_cycle_i - offset;
        gap_ext   = {{(CYC_W-GAP_W){1'b0}}, gap_i};
        if (gap_ext > offset) begin
            back = ((gap_ext - offset + STEP - CYC_W'(1)) / STEP) * STEP;
        end else begin
            back = '0;
        end
        first_win_o = (sec_win_o >= back) ? (sec_win_o - back) : '0;
    end
endmodule

// File: rtl/slot_search.sv
// slot_search: walks the windows forward until the request fits.
// The walk is unrolled a fixed number of times. That bound covers every
// full window the table can hold plus the largest look-back.
// Assumes the table view given to it holds only live entries.
module slot_search #(
    parameter int unsigned CYC_W   = 16,
    parameter int unsigned GAP_W   = 4,
    parameter int unsigned WIN_LEN = 4,
    parameter int unsigned N_ENT   = 8,
    parameter int unsigned MAX_CMD = 2,
    parameter int unsigned CNT_W   = 2
) (
    input  logic [N_ENT-1:0]            live_i,
    input  logic [N_ENT-1:0][CYC_W-1:0] start_i,
    input  logic [N_ENT-1:0][CNT_W-1:0] cnt_i,
    input  logic [CYC_W-1:0]            req_cycle_i,
    input  logic [CYC_W-1:0]            sec_win_i,
    input  logic [CYC_W-1:0]            first_win_i,
    input  logic                        two_i,
    input  logic [GAP_W-1:0]            gap_i,
    output logic [CYC_W-1:0]            grant_sec_o,
    output logic [CYC_W-1:0]            sec_win_o,
    output logic [CYC_W-1:0]            first_win_o
);
    localparam int unsigned      ITER  = 2 * (N_ENT + 2) + (1 << GAP_W) / WIN_LEN + 2;
    localparam logic [CYC_W-1:0] STEP  = CYC_W'(WIN_LEN);
    localparam logic [CNT_W:0]   LIMIT = (CNT_W+1)'(MAX_CMD);

    logic [CYC_W-1:0] sw, fw, g2, gap_ext;
    logic [CNT_W:0]   c1, c2;
    logic             done, same, f_ok, s_ok, too_far;

    // Returns the occupancy of window w in the live table.
    function automatic logic [CNT_W:0] occ(input logic [CYC_W-1:0] w);
        logic [CNT_W:0] r;
        r = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (live_i[i] && start_i[i] == w) r = {1'b0, cnt_i[i]};
        end
        return r;
    endfunction

    // Moves the second phase past full windows and keeps the first phase within the gap.
    always_comb begin
        sw      = sec_win_i;
        fw      = first_win_i;
        g2      = req_cycle_i;
        gap_ext = {{(CYC_W-GAP_W){1'b0}}, gap_i};
        done    = 1'b0;
        same    = 1'b0;
        f_ok    = 1'b0;
        s_ok    = 1'b0;
        too_far = 1'b0;
        c1      = '0;
        c2      = '0;
        for (int it = 0; it < ITER; it++) begin
            if (!done) begin
                same = (sw == fw);
                c1   = occ(fw);
                c2   = (two_i && same) ? c1 + (CNT_W+1)'(1) : occ(sw);
                f_ok = !two_i || (c1 < LIMIT);
                s_ok = c2 < LIMIT;
                if (f_ok && s_ok) begin
                    done = 1'b1;
                end else begin
                    if (!s_ok) begin
                        sw = sw + STEP;
                        g2 = sw;
                    end
                    too_far = !same && ((sw - fw) > gap_ext);
                    if (!f_ok || (!s_ok && too_far)) fw = fw + STEP;
                end
            end
        end
        grant_sec_o = g2;
        sec_win_o   = sw;
        first_win_o = fw;
    end
endmodule

// File: rtl/slot_table.sv
// slot_table: holds the window start and count of each tracked window.
// Every cycle it drops windows that start before cur_cycle.
// Up to two insertions arrive per cycle. An insertion raises the count of a
// matching entry, or claims the lowest free entry if there is none.
// Windows that start before cur_cycle are not recorded.
// Assumes the caller only inserts when enough entries are free.
module slot_table #(
    parameter int unsigned CYC_W  = 16,
    parameter int unsigned N_ENT  = 8,
    parameter int unsigned CNT_W  = 2,
    parameter int unsigned FREE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CYC_W-1:0]            cur_cycle_i,
    input  logic                        ins_a_en_i,
    input  logic [CYC_W-1:0]            ins_a_win_i,
    input  logic                        ins_b_en_i,
    input  logic [CYC_W-1:0]            ins_b_win_i,
    output logic [N_ENT-1:0]            valid_o,
    output logic [N_ENT-1:0]            live_o,
    output logic [N_ENT-1:0][CYC_W-1:0] start_o,
    output logic [N_ENT-1:0][CNT_W-1:0] cnt_o,
    output logic [FREE_W-1:0]           free_o
);
    logic [N_ENT-1:0]            valid_q, nv;
    logic [N_ENT-1:0][CYC_W-1:0] start_q, ns;
    logic [N_ENT-1:0][CNT_W-1:0] cnt_q, nc;
    logic                        en, hit;
    logic [CYC_W-1:0]            w;

    // Live view: valid entries whose window has not started in the past.
    always_comb begin
        free_o = FREE_W'(N_ENT);
        for (int i = 0; i < N_ENT; i++) begin
            live_o[i] = valid_q[i] && (start_q[i] >= cur_cycle_i);
            if (live_o[i]) free_o = free_o - FREE_W'(1);
        end
    end

    // Next table state: the pruned view with the two insertions applied in turn.
    always_comb begin
        nv  = live_o;
        ns  = start_q;
        nc  = cnt_q;
        hit = 1'b0;
        en  = 1'b0;
        w   = '0;
        for (int k = 0; k < 2; k++) begin
            en  = (k == 0) ? ins_a_en_i : ins_b_en_i;
            w   = (k == 0) ? ins_a_win_i : ins_b_win_i;
            hit = 1'b0;
            if (en && (w >= cur_cycle_i)) begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (!hit && nv[i] && ns[i] == w) begin
                        nc[i] = nc[i] + CNT_W'(1);
                        hit   = 1'b1;
                    end
                end
                for (int i = 0; i < N_ENT; i++) begin
                    if (!hit && !nv[i]) begin
                        nv[i] = 1'b1;
                        ns[i] = w;
                        nc[i] = CNT_W'(1);
                        hit   = 1'b1;
                    end
                end
            end
        end
    end

    // Table registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            valid_q <= nv;
            start_q <= ns;
            cnt_q   <= nc;
        end
    end

    assign valid_o = valid_q;
    assign start_o = start_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/cmd_slot_alloc.sv
// cmd_slot_alloc: grants command-bus slots per burst-sized window.
// A request is accepted when the table has room for every window it might
// record. Its grant is returned one cycle after acceptance.
// Assumes cur_cycle never decreases, and that requests do not point so far
// ahead that cycle arithmetic wraps.
module cmd_slot_alloc
    import slot_pkg::*;
#(
    parameter int unsigned CYC_W         = DEF_CYC_W,
    parameter int unsigned WIN_LEN       = DEF_WIN_LEN,
    parameter int unsigned BURST_LEN     = DEF_BURST_LEN,
    parameter int unsigned BEATS_PER_CLK = DEF_BEATS_PER_CLK,
    parameter int unsigned N_ENT         = DEF_N_ENT,
    parameter int unsigned GAP_W         = DEF_GAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cur_cycle,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CYC_W-1:0] req_cycle,
    input  logic             req_two_phase,
    input  logic [GAP_W-1:0] req_gap,
    output logic             grant_valid,
    output logic [CYC_W-1:0] grant_second,
    output logic [CYC_W-1:0] grant_first
);
    localparam int unsigned MAX_CMD = BURST_LEN / BEATS_PER_CLK;
    localparam int unsigned CNT_W   = $clog2(MAX_CMD + 1);
    localparam int unsigned FREE_W  = $clog2(N_ENT + 1);

    logic [N_ENT-1:0]            tbl_valid, tbl_live;
    logic [N_ENT-1:0][CYC_W-1:0] tbl_start;
    logic [N_ENT-1:0][CNT_W-1:0] tbl_cnt;
    logic [FREE_W-1:0]           tbl_free;
    logic [CYC_W-1:0]            sec_win0, first_win0, g_sec, sec_win, first_win;
    logic                        accept;

    slot_align #(.CYC_W(CYC_W), .GAP_W(GAP_W), .WIN_LEN(WIN_LEN)) align_i (
        .req_cycle_i (req_cycle),
        .gap_i       (req_gap),
        .sec_win_o   (sec_win0),
        .first_win_o (first_win0)
    );

    slot_search #(.CYC_W(CYC_W), .GAP_W(GAP_W), .WIN_LEN(WIN_LEN), .N_ENT(N_ENT),
                  .MAX_CMD(MAX_CMD), .CNT_W(CNT_W)) search_i (
        .live_i      (tbl_live),
        .start_i     (tbl_start),
        .cnt_i       (tbl_cnt),
        .req_cycle_i (req_cycle),
        .sec_win_i   (sec_win0),
        .first_win_i (first_win0),
        .two_i       (req_two_phase),
        .gap_i       (req_gap),
        .grant_sec_o (g_sec),
        .sec_win_o   (sec_win),
        .first_win_o (first_win)
    );

    slot_table #(.CYC_W(CYC_W), .N_ENT(N_ENT), .CNT_W(CNT_W), .FREE_W(FREE_W)) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_cycle_i (cur_cycle),
        .ins_a_en_i  (accept),
        .ins_a_win_i (sec_win),
        .ins_b_en_i  (accept && req_two_phase),
        .ins_b_win_i (first_win),
        .valid_o     (tbl_valid),
        .live_o      (tbl_live),
        .start_o     (tbl_start),
        .cnt_o       (tbl_cnt),
        .free_o      (tbl_free)
    );

    // Accept only when every window the request may record has a free entry.
    always_comb begin
        req_ready = int'(tbl_free) >= (req_two_phase ? 2 : 1);
        accept    = req_valid && req_ready;
    end

    // Grant register: result appears in the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_second <= '0;
            grant_first  <= '0;
        end else begin
            grant_valid <= accept;
            if (accept) begin
                grant_second <= g_sec;
                grant_first  <= req_two_phase ? first_win : g_sec;
            end
        end
    end
endmodule

// File: rtl/cmd_slot_alloc_chk.sv
// cmd_slot_alloc_chk: cycle-by-cycle properties of the slot allocator,
// bound into every instance of cmd_slot_alloc.
module cmd_slot_alloc_chk #(
    parameter int unsigned CYC_W   = 16,
    parameter int unsigned WIN_LEN = 4,
    parameter int unsigned N_ENT   = 8,
    parameter int unsigned MAX_CMD = 2,
    parameter int unsigned CNT_W   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CYC_W-1:0]            cur_cycle,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [CYC_W-1:0]            req_cycle,
    input logic                        req_two_phase,
    input logic                        grant_valid,
    input logic [CYC_W-1:0]            grant_second,
    input logic [CYC_W-1:0]            grant_first,
    input logic [N_ENT-1:0]            tbl_valid,
    input logic [N_ENT-1:0]            tbl_live,
    input logic [N_ENT-1:0][CYC_W-1:0] tbl_start,
    input logic [N_ENT-1:0][CNT_W-1:0] tbl_cnt
);
    localparam logic [CYC_W-1:0] STEP = CYC_W'(WIN_LEN);

    // R9
    grant_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> grant_valid);

    // R8
    no_grant_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !grant_valid);

    // R8
    ready_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (int'(N_ENT) - $countones(tbl_live)) >= (req_two_phase ? 2 : 1));

    // R3
    moved_grant_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_second == $past(req_cycle)) ||
                        (grant_second > $past(req_cycle) && (grant_second % STEP) == '0));

    // R9
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_first <= grant_second);

    // R9
    single_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !$past(req_two_phase)) |-> grant_first == grant_second);

    // R4
    first_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(req_two_phase)) |-> (grant_first % STEP) == '0);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        // R2
        window_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_live[i] |-> (tbl_cnt[i] != '0) && (int'(tbl_cnt[i]) <= int'(MAX_CMD)));

        // R7
        no_past_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_valid[i] |-> tbl_start[i] >= $past(cur_cycle));
    end
endmodule

bind cmd_slot_alloc cmd_slot_alloc_chk #(
    .CYC_W(CYC_W), .WIN_LEN(WIN_LEN), .N_ENT(N_ENT), .MAX_CMD(MAX_CMD), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cur_cycle(cur_cycle), .req_valid(req_valid),
    .req_ready(req_ready), .req_cycle(req_cycle), .req_two_phase(req_two_phase),
    .grant_valid(grant_valid), .grant_second(grant_second), .grant_first(grant_first),
    .tbl_valid(tbl_valid), .tbl_live(tbl_live), .tbl_start(tbl_start), .tbl_cnt(tbl_cnt)
);

// File: tb/cmd_slot_alloc_tb_top.sv
// Bench for cmd_slot_alloc: directed corner cases plus a sweep over every gap
// and window offset. Expected grants come from an arithmetic window model.
module cmd_slot_alloc_tb_top;
    localparam int CYC_W = 16;
    localparam int W     = 4;
    localparam int N_ENT = 8;
    localparam int MAXC  = 2;
    localparam int GAP_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CYC_W-1:0] cur_cycle = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [CYC_W-1:0] req_cycle = '0;
    logic             req_two_phase = 1'b0;
    logic [GAP_W-1:0] req_gap = '0;
    logic             grant_valid;
    logic [CYC_W-1:0] grant_second, grant_first;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int mcnt [0:1023];
    int cur = 0;

    always #10 clk = ~clk;

    cmd_slot_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .cur_cycle(cur_cycle), .req_valid(req_valid),
        .req_ready(req_ready), .req_cycle(req_cycle), .req_two_phase(req_two_phase),
        .req_gap(req_gap), .grant_valid(grant_valid), .grant_second(grant_second),
        .grant_first(grant_first)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model occupancy: windows starting before the current cycle count as empty.
    function automatic int mcount(input int start);
        if (start < cur) return 0;
        return mcnt[start / W];
    endfunction

    function automatic int mlive();
        int n = 0;
        for (int w = 0; w < 1024; w++) if (mcnt[w] > 0 && w * W >= cur) n++;
        return n;
    endfunction

    task automatic set_cur(input int c);
        @(negedge clk);
        cur = c;
        cur_cycle = CYC_W'(c);
    endtask

    // Present one request, predict ready and the grant, compare both.
    task automatic issue(input int cyc, input bit two, input int gap, input string req);
        int off, sw, fw, g2, bo, c1, c2;
        bit exp_rdy, same, fok, sok, far;
        @(negedge clk);
        req_valid = 1'b1;
        req_cycle = CYC_W'(cyc);
        req_two_phase = two;
        req_gap = GAP_W'(gap);
        #1;
        exp_rdy = (N_ENT - mlive()) >= (two ? 2 : 1);
        check(req_ready == exp_rdy, exp_rdy ? req : "R8", "ready", int'(req_ready), int'(exp_rdy));
        off = cyc % W;
        sw = cyc - off;
        g2 = cyc;
        bo = 0;
        if (two) while (gap > off + bo) bo += W;
        fw = two ? (sw - ((bo < sw) ? bo : sw)) : sw;
        for (int it = 0; it < 100; it++) begin
            same = (sw == fw);
            c1 = mcount(fw);
            c2 = (two && same) ? c1 + 1 : mcount(sw);
            fok = !two || c1 < MAXC;
            sok = c2 < MAXC;
            if (fok && sok) break;
            if (!sok) begin sw += W; g2 = sw; end
            far = !same && (sw - fw > gap);
            if (two && (!fok || (!sok && far))) fw += W;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(grant_valid == exp_rdy, exp_rdy ? "R9" : "R8", "grant_valid",
              int'(grant_valid), int'(exp_rdy));
        if (exp_rdy) begin
            check(int'(grant_second) == g2, req, "grant_second", int'(grant_second), g2);
            check(int'(grant_first) == (two ? fw : g2), req, "grant_first",
                  int'(grant_first), two ? fw : g2);
            if (sw >= cur) mcnt[sw / W]++;
            if (two && fw >= cur) mcnt[fw / W]++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        for (int w = 0; w < 1024; w++) mcnt[w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: empty table after reset
        check(grant_valid == 1'b0, "R10", "grant_valid", int'(grant_valid), 0);
        check(req_ready == 1'b1, "R10", "ready", int'(req_ready), 1);

        // R1: free window keeps the requested cycle; R2: two per window
        issue(5, 0, 0, "R1");
        issue(6, 0, 0, "R2");
        // R3: full window pushes to the next start, repeatedly
        issue(7, 0, 0, "R3");
        issue(4, 0, 0, "R3");
        issue(4, 0, 0, "R3");
        // R4: look-back clamped at zero
        issue(2, 1, 15, "R4");
        // R5: shared window with one used slot pushes the second phase on
        set_cur(200);
        issue(200, 0, 0, "R5");
        issue(201, 1, 0, "R5");
        issue(201, 1, 3, "R6");

        // R8 and R7: fill the table, see stall, then prune to free an entry
        set_cur(400);
        for (int k = 0; k < 8; k++) issue(400 + 4 * k, 0, 0, "R8");
        issue(432, 0, 0, "R8");
        set_cur(404);
        issue(440, 0, 0, "R7");
        issue(444, 1, 2, "R8");

        // R4 R5 R6: sweep every gap and offset against a full window
        base = 600;
        for (int g = 0; g < 16; g++) begin
            for (int o = 0; o < W; o++) begin
                set_cur(base);
                issue(base + 12, 0, 0, "R3");
                issue(base + 12, 0, 0, "R2");
                issue(base + 12 + o, 1, g, "R6");
                issue(base + 12 + o, 1, g, "R4");
                issue(base + 8 + o, 1, g, "R5");
                base += 40;
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule